// File: doc/BRIEF.md
# CAN Receive Frame Ring

This block is the receive store of a CAN controller. It holds accepted frames as packed byte records in a circular byte array. Each record is laid out as a header byte, then the identifier bytes, then the data bytes. The acceptance stage hands over one whole frame per cycle: a header byte plus a 12-byte body. The ring keeps only as many bytes as the header says the record needs.

The host sees the oldest record through a byte window. Window offset k addresses the byte k places past the ring's start pointer, wrapping modulo the ring size. A release command drops the oldest record by moving the start pointer past it. The distance is decoded from that record's own stored header. The block keeps a stored-byte count and a stored-message count. It also keeps a receive-available status, a receive interrupt flag, and overrun status and interrupt flags.

A mode input models the controller's configuration (reset) mode. While the input is high, pushes and releases are ignored. The cycle in which it drops empties the ring.

Top module: `can_rx_ring`

## Requirements
- R1: A record is stored as the header byte (bit 7 = extended format, bit 6 = remote request, bits 3..0 = DLC), then `in_body` bytes 0,1,2,… (body byte j sits in bits 8j+7..8j). The record length is 5+D for an extended header and 3+D for a standard one, where D is the effective data count.
- R2: A DLC above 8 gives D = 8, so at most 8 data bytes are stored.
- R3: A push whose length, added to the current byte count, would exceed DEPTH is dropped. The counts and ring contents stay unchanged, and `ovr_sts` and `ovr_irq` are set one cycle later. A frame that fills the ring exactly is accepted.
- R4: An accepted push adds its length to `byte_count` and one to `msg_count`. The write position advances by that length modulo DEPTH.
- R5: A release while `msg_count` is zero changes nothing: the counts and the window contents stay as they were.
- R6: A release with messages present moves the start pointer by the length decoded from the oldest stored header, modulo DEPTH. It lowers `byte_count` by that length and `msg_count` by one.
- R7: When a release brings `msg_count` to zero, `rx_avail` and `rx_irq` go low. An accepted push sets both.
- R8: `win_byte` shows the ring byte at (start + `win_ofs`) modulo DEPTH, combinationally.
- R9: While `cfg_mode` is high, pushes and releases are ignored. In the first cycle after it falls, both counts clear, `rx_avail` and `rx_irq` clear, and the window start moves to the write position.
- R10: `irq_ack` clears `rx_irq` and `ovr_irq` and leaves `ovr_sts` alone. `ovr_clr` clears `ovr_sts`.
- R11: After `rst_n` is asserted, both counts are zero, all four flags are low, and the block is in configuration mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode; high blocks traffic, falling edge empties the ring |
| in_valid | input | 1 | Push one frame this cycle |
| in_hdr | input | 8 | Header byte of the pushed frame |
| in_body | input | 96 | Identifier and data bytes following the header, byte 0 lowest |
| rel_req | input | 1 | Release the oldest record |
| irq_ack | input | 1 | Clear both interrupt flags |
| ovr_clr | input | 1 | Clear overrun status |
| win_ofs | input | $clog2(DEPTH) | Window offset from the start pointer |
| win_byte | output | 8 | Ring byte at start + offset |
| byte_count | output | $clog2(DEPTH)+1 | Bytes held |
| msg_count | output | $clog2(DEPTH)+1 | Records held |
| rx_avail | output | 1 | At least one record held |
| rx_irq | output | 1 | Receive interrupt flag |
| ovr_sts | output | 1 | Overrun status |
| ovr_irq | output | 1 | Overrun interrupt flag |

## Verification
A start pointer that drifts from the true record boundary shows up at once in the window. Offset 0 then no longer returns the header that was pushed. The next release moves by a wrong length, so every later record reads as shifted bytes. A byte count that disagrees with the records held shows up on `byte_count` in the same cycle. It shows up again at the overrun boundary, where a frame that fits exactly is wrongly dropped or an oversize one is kept. The bench mirrors the ring byte for byte and checks the counts, the flags and all thirteen window bytes after every operation. Any corruption therefore surfaces at the first check after the faulty cycle, including when records straddle the wrap point.

// File: rtl/can_rx_ring_pkg.sv
package can_rx_ring_pkg;

    localparam int REC_MAX  = 13;          // header + 4 id + 8 data
    localparam int BODY_W   = (REC_MAX - 1) * 8;
    localparam int HDR_EXT  = 7;
    localparam int DATA_MAX = 8;

    function automatic logic [3:0] rec_len(input logic [7:0] hdr);
        logic [3:0] dcnt;
        dcnt = (hdr[3:0] > 4'(DATA_MAX)) ? 4'(DATA_MAX) : hdr[3:0];
        return hdr[HDR_EXT] ? dcnt + 4'd5 : dcnt + 4'd3;
    endfunction

endpackage

// File: rtl/can_rx_len.sv
module can_rx_len
    import can_rx_ring_pkg::*;
(
    input  logic [7:0] hdr_i,
    output logic [3:0] len_o
);
    always_comb begin
        len_o = rec_len(hdr_i);
    end
endmodule

// File: rtl/can_rx_mem.sv
module can_rx_mem
    import can_rx_ring_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [AW-1:0]          wbase_i,
    input  logic [3:0]             wlen_i,
    input  logic [REC_MAX*8-1:0]   wrec_i,
    input  logic [AW-1:0]          rbase_i,
    input  logic [AW-1:0]          rofs_i,
    output logic [7:0]             rdata_o,
    output logic [7:0]             head_o
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < REC_MAX; i++) begin
            if (we_i && (4'(i) < wlen_i)) begin
                mem_d[wbase_i + AW'(i)] = wrec_i[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[rbase_i + rofs_i];
    assign head_o  = mem_q[rbase_i];

    AST_WLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) we_i |-> (wlen_i >= 4'd3 && wlen_i <= 4'(REC_MAX))); // R1
endmodule

// File: rtl/can_rx_ring.sv
module can_rx_ring
    import can_rx_ring_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              in_valid,
    input  logic [7:0]        in_hdr,
    input  logic [BODY_W-1:0] in_body,
    input  logic              rel_req,
    input  logic              irq_ack,
    input  logic              ovr_clr,
    input  logic [AW-1:0]     win_ofs,
    output logic [7:0]        win_byte,
    output logic [CW-1:0]     byte_count,
    output logic [CW-1:0]     msg_count,
    output logic              rx_avail,
    output logic              rx_irq,
    output logic              ovr_sts,
    output logic              ovr_irq
);
    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] wp;
        logic [CW-1:0] nbytes;
        logic [CW-1:0] nmsgs;
        logic          avail;
        logic          rxirq;
        logic          ovrsts;
        logic          ovrirq;
        logic          rmode;
    } ring_st_t;

    ring_st_t   st_q, st_d;
    logic [3:0] in_len, head_len;
    logic [7:0] head_byte;
    logic       leave, op, fit, store, drop, rel;

    can_rx_len u_len_in   (.hdr_i(in_hdr),    .len_o(in_len));
    can_rx_len u_len_head (.hdr_i(head_byte), .len_o(head_len));

    can_rx_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store),
        .wbase_i (st_q.wp),
        .wlen_i  (in_len),
        .wrec_i  ({in_body, in_hdr}),
        .rbase_i (st_q.start),
        .rofs_i  (win_ofs),
        .rdata_o (win_byte),
        .head_o  (head_byte)
    );

    always_comb begin
        st_d  = st_q;
        leave = st_q.rmode && !cfg_mode;
        op    = !st_q.rmode && !cfg_mode;
        fit   = ({1'b0, st_q.nbytes} + (CW+1)'(in_len)) <= (CW+1)'(DEPTH);
        store = op && in_valid && fit;
        drop  = op && in_valid && !fit;
        rel   = op && rel_req && (st_q.nmsgs != '0);

        st_d.rmode = cfg_mode;

        if (irq_ack) begin
            st_d.rxirq  = 1'b0;
            st_d.ovrirq = 1'b0;
        end
        if (ovr_clr) st_d.ovrsts = 1'b0;

        if (rel) begin
            st_d.start  = st_q.start + AW'(head_len);
            st_d.nbytes = st_q.nbytes - CW'(head_len);
            st_d.nmsgs  = st_q.nmsgs - CW'(1);
            if (st_q.nmsgs == CW'(1)) begin
                st_d.avail = 1'b0;
                st_d.rxirq = 1'b0;
            end
        end
        if (store) begin
            st_d.wp     = st_q.wp + AW'(in_len);
            st_d.nbytes = st_d.nbytes + CW'(in_len);
            st_d.nmsgs  = st_d.nmsgs + CW'(1);
            st_d.avail  = 1'b1;
            st_d.rxirq  = 1'b1;
        end
        if (drop) begin
            st_d.ovrsts = 1'b1;
            st_d.ovrirq = 1'b1;
        end
        if (leave) begin
            st_d.start  = st_q.wp;
            st_d.nbytes = '0;
            st_d.nmsgs  = '0;
            st_d.avail  = 1'b0;
            st_d.rxirq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rmode <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_count = st_q.nbytes;
    assign msg_count  = st_q.nmsgs;
    assign rx_avail   = st_q.avail;
    assign rx_irq     = st_q.rxirq;
    assign ovr_sts    = st_q.ovrsts;
    assign ovr_irq    = st_q.ovrirq;

    AST_BYTES_BOUND: assert property (@(posedge clk) disable iff (!rst_n) byte_count <= CW'(DEPTH)); // R3
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (drop && !rel_req && !irq_ack) |=> (ovr_sts && ovr_irq && $stable(msg_count) && $stable(byte_count))); // R3
    AST_EMPTY_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n) (msg_count == '0) |-> (byte_count == '0)); // R4
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (op && rel_req && !in_valid && msg_count == '0) |=> ($stable(st_q.start) && $stable(byte_count))); // R5
    AST_AVAIL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) rx_avail == (msg_count != '0)); // R7
    AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (st_q.rmode && !cfg_mode) |=> (msg_count == '0 && byte_count == '0 && !rx_irq)); // R9
endmodule

// File: tb/can_rx_ring_bench.sv
module can_rx_ring_bench;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_hdr = '0;
    logic [95:0] in_body = '0;
    logic        rel_req = 1'b0;
    logic        irq_ack = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [AW-1:0] win_ofs = '0;
    logic [7:0]  win_byte;
    logic [AW:0] byte_count, msg_count;
    logic        rx_avail, rx_irq, ovr_sts, ovr_irq;

    int errors = 0;
    int checks = 0;

    // bench model of the ring
    logic [7:0] m_mem [DEPTH];
    int m_start = 0, m_wp = 0, m_bytes = 0, m_msgs = 0;
    bit m_avail = 0, m_rxirq = 0, m_ovrsts = 0, m_ovrirq = 0, m_cfg = 1;

    always #5 clk = ~clk;

    can_rx_ring #(.DEPTH(DEPTH)) u_can_rx_ring (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .in_valid(in_valid),
        .in_hdr(in_hdr), .in_body(in_body), .rel_req(rel_req), .irq_ack(irq_ack),
        .ovr_clr(ovr_clr), .win_ofs(win_ofs), .win_byte(win_byte),
        .byte_count(byte_count), .msg_count(msg_count), .rx_avail(rx_avail),
        .rx_irq(rx_irq), .ovr_sts(ovr_sts), .ovr_irq(ovr_irq)
    );

    function automatic int frame_len(input logic [7:0] h);
        int d;
        d = (h[3:0] > 8) ? 8 : int'(h[3:0]);
        return h[7] ? 5 + d : 3 + d;
    endfunction

    function automatic logic [95:0] mk_body(input logic [7:0] seed);
        logic [95:0] b;
        for (int j = 0; j < 12; j++) b[j*8 +: 8] = seed + 8'(j * 7);
        return b;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "byte_count", int'(byte_count), m_bytes);
        chk(req, "msg_count", int'(msg_count), m_msgs);
        chk(req, "rx_avail", int'(rx_avail), int'(m_avail));
        chk(req, "rx_irq", int'(rx_irq), int'(m_rxirq));
        chk(req, "ovr_sts", int'(ovr_sts), int'(m_ovrsts));
        chk(req, "ovr_irq", int'(ovr_irq), int'(m_ovrirq));
        for (int k = 0; k < 13; k++) begin
            win_ofs = AW'(k);
            #0.5;
            chk(req, $sformatf("window[%0d]", k), int'(win_byte), int'(m_mem[(m_start + k) % DEPTH]));
        end
        win_ofs = '0;
    endtask

    task automatic push(input logic [7:0] h, input logic [7:0] seed);
        logic [95:0] b;
        int len;
        b = mk_body(seed);
        @(negedge clk);
        in_valid = 1'b1; in_hdr = h; in_body = b;
        @(negedge clk);
        in_valid = 1'b0;
        len = frame_len(h);
        if (!m_cfg) begin
            if (m_bytes + len <= DEPTH) begin
                m_mem[m_wp] = h;
                for (int j = 0; j < len - 1; j++) m_mem[(m_wp + 1 + j) % DEPTH] = b[j*8 +: 8];
                m_wp = (m_wp + len) % DEPTH;
                m_bytes += len; m_msgs++; m_avail = 1; m_rxirq = 1;
            end else begin
                m_ovrsts = 1; m_ovrirq = 1;
            end
        end
    endtask

    task automatic release_one();
        int hl;
        @(negedge clk);
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        if (!m_cfg && m_msgs > 0) begin
            hl = frame_len(m_mem[m_start]);
            m_start = (m_start + hl) % DEPTH;
            m_bytes -= hl; m_msgs--;
            if (m_msgs == 0) begin m_avail = 0; m_rxirq = 0; end
        end
    endtask

    task automatic t_reset();
        chk("R11", "byte_count", int'(byte_count), 0);
        chk("R11", "msg_count", int'(msg_count), 0);
        chk("R11", "flags", int'({rx_avail, rx_irq, ovr_sts, ovr_irq}), 0);
        // still in configuration mode: push ignored
        push(8'h02, 8'h10);
        chk("R11", "push in config mode ignored", int'(msg_count), 0);
        @(negedge clk); cfg_mode = 1'b0; m_cfg = 0;
        @(negedge clk);
        m_start = m_wp; m_bytes = 0; m_msgs = 0; m_avail = 0; m_rxirq = 0;
        check_all("R11");
    endtask

    task automatic t_store();
        push(8'h02, 8'h20);          // standard, DLC 2 -> 5 bytes
        check_all("R1");
        push(8'h83, 8'h40);          // extended, DLC 3 -> 8 bytes
        check_all("R4");
        chk("R4", "byte_count sum", int'(byte_count), 13);
        push(8'h4F, 8'h60);          // standard remote, DLC 15 -> 11 bytes
        check_all("R2");
        chk("R2", "clamped length", int'(byte_count), 24);
    endtask

    task automatic t_release();
        release_one();
        check_all("R6");
        chk("R6", "header of new head", int'(win_byte), 8'h83);
        release_one();
        check_all("R8");
        release_one();
        check_all("R7");
        chk("R7", "rx_avail low", int'(rx_avail), 0);
        chk("R7", "rx_irq low", int'(rx_irq), 0);
        release_one();
        check_all("R5");
        chk("R5", "msg_count stays", int'(msg_count), 0);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 4; i++) push(8'h88, 8'(8'h80 + i * 16));   // 4 x 13 = 52
        check_all("R4");
        push(8'h87, 8'hC0);          // 12 bytes, exact fit 64
        check_all("R3");
        chk("R3", "exact fit accepted", int'(byte_count), 64);
        push(8'h00, 8'hD0);          // 3 bytes, must drop
        check_all("R3");
        chk("R3", "ovr_irq set", int'(ovr_irq), 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; m_rxirq = 0; m_ovrirq = 0;
        check_all("R10");
        chk("R10", "ovr_sts kept", int'(ovr_sts), 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0; m_ovrsts = 0;
        check_all("R10");
        for (int i = 0; i < 5; i++) begin
            release_one();
            check_all("R8");
        end
        chk("R6", "drained", int'(byte_count), 0);
    endtask

    task automatic t_cfg_mode();
        push(8'h81, 8'hE0);
        check_all("R9");
        @(negedge clk); cfg_mode = 1'b1; m_cfg = 1;
        @(negedge clk);
        push(8'h05, 8'hF0);
        release_one();
        check_all("R9");
        chk("R9", "held during config", int'(msg_count), 1);
        @(negedge clk); cfg_mode = 1'b0; m_cfg = 0;
        @(negedge clk);
        m_start = m_wp; m_bytes = 0; m_msgs = 0; m_avail = 0; m_rxirq = 0;
        check_all("R9");
        chk("R9", "counts cleared", int'(msg_count), 0);
        push(8'h01, 8'h33);
        check_all("R4");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_release();
        t_overrun();
        t_cfg_mode();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule